// File: doc/BRIEF.md
# Fractional Time-Unit Tick Generator

This block produces the local time-unit tick of a time-triggered bus controller. The length of one unit is the clock period scaled by a ratio NC/DC. NC is an 18-bit numerator whose two top bits are fixed at binary 01, and DC is a 14-bit denominator. Each clock an accumulator adds DC. When the sum reaches the active numerator, the block emits a one-cycle tick, subtracts the numerator and keeps the remainder. Over time the tick rate therefore averages exactly DC/NC ticks per clock.

The numerator in use, called the active numerator, starts at the configured NC. A clock-drift estimator outside the block may request a signed offset from NC. The block clamps that offset to a window whose size comes from a 3-bit limit field, and it ignores such requests entirely in operating level 1. A small register port writes the numerator's low half, the denominator, and a control word holding the operating level and the limit. The same port reads back each of these and the active numerator. The block also checks that NC is large enough compared with DC for the selected level. While that check fails, the block raises an error flag and keeps the tick quiet.

Top module: `ntu_tick_gen`

## Requirements
- R1: After reset the configured numerator is 0x10000, the denominator is 0x1000, the operating level and the limit are 0, the active numerator is 0x10000, tick is low and ratio_err is low.
- R2: A write with cfg_sel=0 loads cfg_wdata[15:0] as the low 16 bits of NC. The upper two bits always read as 01, so NC lies between 0x10000 and 0x1FFFF.
- R3: A write with cfg_sel=1 loads cfg_wdata[13:0] into DC when that value is non-zero. A write of zero is rejected and DC keeps its previous value.
- R4: Each clock in which the block runs, the accumulator adds DC. If the sum is at least the active numerator, tick is high for the following cycle and the accumulator keeps the sum minus the numerator. Otherwise the accumulator keeps the sum and tick is low. A tick never lasts two cycles.
- R5: Any configuration write clears the accumulator to zero and forces tick low for the following cycle.
- R6: In level 1 the rule is NC >= 4*DC. In levels 0, 2 and 3 the rule is NC >= 8*DC. While the rule fails, ratio_err is high, the accumulator is held at zero and tick stays low.
- R7: In levels 0, 2 and 3, a correction request with signed offset corr_off sets the active numerator to NC plus the offset. The offset is first clamped to the range -2^(L+5) to +2^(L+5), where L is the limit field. DC is never changed by a correction.
- R8: In level 1 correction requests have no effect on the active numerator.
- R9: A numerator write sets the active numerator to the new NC, and a control write sets it back to the current NC. Either write takes priority over a correction in the same cycle.
- R10: cfg_rdata shows the value selected by cfg_sel: 0 gives the full 18-bit NC, 1 gives DC, 2 gives {limit[2:0], level[1:0]} in bits [4:0], and 3 gives the active numerator. The control write uses the same layout in cfg_wdata[4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 numerator, 1 denominator, 2 control, 3 active numerator (read only) |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 18 | Read data for the selected register |
| corr_valid | input | 1 | Correction request strobe |
| corr_off | input | 16 | Signed requested offset of the active numerator from NC |
| tick | output | 1 | One-cycle time-unit pulse |
| active_num | output | 18 | Active numerator |
| ratio_err | output | 1 | NC/DC ratio rule violated for the current level |

## Verification
The hardest state to reach from the ports is a ratio violation sitting exactly at its boundary. NC is at least 0x10000 by construction, so the default denominator can never break either rule. The stimulus loads DC = 0x2001, steps the NC low half across 7 and 8 so that NC lands on either side of 8*DC, and then switches between levels 1 and 2 without touching NC or DC. Clamping is reached by sweeping every limit value with offsets just inside, exactly at and far beyond each bound, in every level that allows correction. While all of this runs, the bench models the accumulator cycle by cycle.

// File: rtl/ntu_pkg.sv
`timescale 1ns/1ps
package ntu_pkg;
  typedef enum logic [1:0] {
    SEL_NUM  = 2'd0,
    SEL_DEN  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_ACT  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    LVL_0 = 2'd0,
    LVL_1 = 2'd1,
    LVL_2 = 2'd2,
    LVL_3 = 2'd3
  } op_level_e;
endpackage

// File: rtl/ntu_cfg_regs.sv
`timescale 1ns/1ps
module ntu_cfg_regs
  import ntu_pkg::*;
#(
  parameter int NUM_LO_W = 16,
  parameter int DEN_W    = 14,
  parameter int LIM_W    = 3,
  parameter int DEN_RST  = 'h1000,
  parameter int SH_L1    = 2,
  parameter int SH_OTHER = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  cfg_sel_e              wr_sel,
  input  logic [NUM_LO_W-1:0]   wr_data,
  output logic [NUM_LO_W+1:0]   nc_full,
  output logic [DEN_W-1:0]      dc_q,
  output op_level_e             lvl_q,
  output logic [LIM_W-1:0]      lim_q,
  output logic                  ratio_ok
);
  localparam int NUM_W = NUM_LO_W + 2;
  localparam int CMP_W = NUM_W + 1;

  logic [NUM_LO_W-1:0] ncl_q, ncl_d;
  logic [DEN_W-1:0]    dc_d, den_wr;
  op_level_e           lvl_d;
  logic [LIM_W-1:0]    lim_d;
  logic [CMP_W-1:0]    dc_ext, min_num;

  assign den_wr = wr_data[DEN_W-1:0];

  always_comb begin
    ncl_d = ncl_q;
    dc_d  = dc_q;
    lvl_d = lvl_q;
    lim_d = lim_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_NUM:  ncl_d = wr_data;
        SEL_DEN:  if (den_wr != '0) dc_d = den_wr;
        SEL_CTRL: begin
          lvl_d = op_level_e'(wr_data[1:0]);
          lim_d = wr_data[LIM_W+1:2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ncl_q <= '0;
      dc_q  <= DEN_W'(DEN_RST);
      lvl_q <= LVL_0;
      lim_q <= '0;
    end else if (wr_en) begin
      ncl_q <= ncl_d;
      dc_q  <= dc_d;
      lvl_q <= lvl_d;
      lim_q <= lim_d;
    end
  end

  assign nc_full = {2'b01, ncl_q};
  assign dc_ext  = CMP_W'(dc_q);

  always_comb begin
    if (lvl_q == LVL_1) min_num = dc_ext << SH_L1;
    else                min_num = dc_ext << SH_OTHER;
  end

  assign ratio_ok = CMP_W'(nc_full) >= min_num;

  AST_ZERO_DEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DEN && wr_data[DEN_W-1:0] == '0) |=> $stable(dc_q)); // R3
endmodule

// File: rtl/ntu_drift.sv
`timescale 1ns/1ps
module ntu_drift #(
  parameter int NUM_W    = 18,
  parameter int OFS_W    = 16,
  parameter int LIM_W    = 3,
  parameter int LIM_BASE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_W-1:0] nc,
  input  logic [LIM_W-1:0] lim,
  input  logic             drift_en,
  input  logic             corr_valid,
  input  logic [OFS_W-1:0] corr_off,
  input  logic             restore,
  input  logic [NUM_W-1:0] restore_val,
  output logic [NUM_W-1:0] nav_q
);
  localparam int BASE_W  = (NUM_W > OFS_W) ? NUM_W : OFS_W;
  localparam int EXT_W   = BASE_W + 2;
  localparam logic [NUM_W-1:0] NAV_RST = NUM_W'(1) << (NUM_W - 2);

  logic signed [EXT_W-1:0] bound, off_s, off_c, tgt, diff;
  logic [NUM_W-1:0]        nav_d;
  logic                    upd_en;

  assign bound = EXT_W'(1) << (EXT_W'(lim) + EXT_W'(LIM_BASE));
  assign off_s = EXT_W'(signed'(corr_off));

  always_comb begin
    if (off_s > bound)       off_c = bound;
    else if (off_s < -bound) off_c = -bound;
    else                     off_c = off_s;
  end

  assign tgt    = signed'(EXT_W'(nc)) + off_c;
  assign upd_en = restore | (corr_valid & drift_en);

  always_comb begin
    if (restore) nav_d = restore_val;
    else         nav_d = tgt[NUM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nav_q <= NAV_RST;
    else if (upd_en) nav_q <= nav_d;
  end

  assign diff = signed'(EXT_W'(nav_q)) - signed'(EXT_W'(nc));

  AST_NAV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (diff <= bound) && (diff >= -bound)); // R7
endmodule

// File: rtl/ntu_accum.sv
`timescale 1ns/1ps
module ntu_accum #(
  parameter int NUM_W = 18,
  parameter int DEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEN_W-1:0] dc,
  input  logic [NUM_W-1:0] nav,
  input  logic             run,
  input  logic             clear,
  output logic             tick_q
);
  localparam int ACC_W = NUM_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic             tick_d, hit;

  assign sum = acc_q + ACC_W'(dc);
  assign hit = sum >= ACC_W'(nav);

  always_comb begin
    if (clear || !run) begin
      acc_d  = '0;
      tick_d = 1'b0;
    end else if (hit) begin
      acc_d  = sum - ACC_W'(nav);
      tick_d = 1'b1;
    end else begin
      acc_d  = sum;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  AST_SINGLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q); // R4
endmodule

// File: rtl/ntu_tick_gen.sv
`timescale 1ns/1ps
module ntu_tick_gen
  import ntu_pkg::*;
#(
  parameter int NUM_LO_W = 16,
  parameter int DEN_W    = 14,
  parameter int LIM_W    = 3,
  parameter int OFS_W    = 16,
  parameter int DEN_RST  = 'h1000,
  parameter int NUM_W    = NUM_LO_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [NUM_LO_W-1:0] cfg_wdata,
  output logic [NUM_W-1:0]    cfg_rdata,
  input  logic                corr_valid,
  input  logic [OFS_W-1:0]    corr_off,
  output logic                tick,
  output logic [NUM_W-1:0]    active_num,
  output logic                ratio_err
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  cfg_sel_e         sel;
  logic [NUM_W-1:0] nc_full, restore_val;
  logic [DEN_W-1:0] dc_q;
  op_level_e        lvl_q;
  logic [LIM_W-1:0] lim_q;
  logic             ratio_ok, restore, drift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign sel = cfg_sel_e'(cfg_sel);

  ntu_cfg_regs #(
    .NUM_LO_W(NUM_LO_W), .DEN_W(DEN_W), .LIM_W(LIM_W), .DEN_RST(DEN_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(cfg_we), .wr_sel(sel), .wr_data(cfg_wdata),
    .nc_full(nc_full), .dc_q(dc_q), .lvl_q(lvl_q), .lim_q(lim_q), .ratio_ok(ratio_ok)
  );

  assign restore     = cfg_we && (sel == SEL_NUM || sel == SEL_CTRL);
  assign restore_val = (sel == SEL_NUM) ? {2'b01, cfg_wdata} : nc_full;
  assign drift_en    = (lvl_q != LVL_1);

  ntu_drift #(
    .NUM_W(NUM_W), .OFS_W(OFS_W), .LIM_W(LIM_W)
  ) u_drift (
    .clk(clk), .rst_n(rst_n_s), .nc(nc_full), .lim(lim_q), .drift_en(drift_en),
    .corr_valid(corr_valid), .corr_off(corr_off), .restore(restore),
    .restore_val(restore_val), .nav_q(active_num)
  );

  ntu_accum #(
    .NUM_W(NUM_W), .DEN_W(DEN_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n_s), .dc(dc_q), .nav(active_num),
    .run(ratio_ok), .clear(cfg_we), .tick_q(tick)
  );

  assign ratio_err = !ratio_ok;

  always_comb begin
    case (sel)
      SEL_NUM:  cfg_rdata = nc_full;
      SEL_DEN:  cfg_rdata = NUM_W'(dc_q);
      SEL_CTRL: cfg_rdata = NUM_W'({lim_q, lvl_q});
      default:  cfg_rdata = active_num;
    endcase
  end

  AST_RATIO_MUTE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ratio_err |=> !tick); // R6
  AST_LVL1_IGNORE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lvl_q == LVL_1 && corr_valid && !cfg_we) |=> $stable(active_num)); // R8
  AST_NUM_RESTORE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_we && sel == SEL_NUM) |=> active_num == {2'b01, $past(cfg_wdata)}); // R9
endmodule

// File: tb/ntu_tick_gen_tb.sv
`timescale 1ns/1ps
module ntu_tick_gen_tb;
  localparam int PER = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic [17:0] cfg_rdata;
  logic        corr_valid = 1'b0;
  logic [15:0] corr_off = '0;
  logic        tick;
  logic [17:0] active_num;
  logic        ratio_err;

  ntu_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .corr_valid(corr_valid), .corr_off(corr_off),
    .tick(tick), .active_num(active_num), .ratio_err(ratio_err)
  );

  always #(PER/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int m_ncl = 0, m_dc = 'h1000, m_lvl = 0, m_lim = 0, m_nav = 'h10000, m_acc = 0;
  bit m_tick = 0;

  function automatic int m_nc();
    return 'h10000 + m_ncl;
  endfunction

  function automatic bit m_rok();
    if (m_lvl == 1) return m_nc() >= 4 * m_dc;
    return m_nc() >= 8 * m_dc;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit we, int sel, int wd, bit cv, int off, string tag);
    int nc, b, o, sum;
    bit rok;
    cfg_we = we; cfg_sel = sel[1:0]; cfg_wdata = wd[15:0];
    corr_valid = cv; corr_off = off[15:0];
    @(posedge clk); #1;
    nc  = m_nc();
    rok = m_rok();
    if (we || !rok) begin
      m_acc = 0; m_tick = 0;
    end else begin
      sum = m_acc + m_dc;
      if (sum >= m_nav) begin m_tick = 1; m_acc = sum - m_nav; end
      else begin m_tick = 0; m_acc = sum; end
    end
    b = 1 << (m_lim + 5);
    o = off;
    if (o > b) o = b;
    if (o < -b) o = -b;
    if (we && sel == 0)      m_nav = 'h10000 + (wd & 'hFFFF);
    else if (we && sel == 2) m_nav = nc;
    else if (cv && m_lvl != 1) m_nav = nc + o;
    if (we) begin
      case (sel)
        0: m_ncl = wd & 'hFFFF;
        1: if ((wd & 'h3FFF) != 0) m_dc = wd & 'h3FFF;
        2: begin m_lvl = wd & 3; m_lim = (wd >> 2) & 7; end
        default: ;
      endcase
    end
    cfg_we = 1'b0; corr_valid = 1'b0;
    chk(tick === m_tick, {tag, " tick"}, tick, m_tick);
    chk(active_num == 18'(m_nav), {tag, " active_num"}, active_num, m_nav);
    chk(ratio_err === !m_rok(), {tag, " ratio_err"}, ratio_err, !m_rok());
  endtask

  task automatic idle(int n, string tag);
    repeat (n) cyc(0, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(int sel, output int v);
    cfg_sel = sel[1:0];
    #1;
    v = int'(cfg_rdata);
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    int offs[7] = '{-6000, -33, -32, 0, 31, 33, 6000};
    int lv[3]   = '{0, 2, 3};
    int pn[5]   = '{'h0000, 'hFFFF, 'h8000, 'h1234, 'h0000};
    int pd[5]   = '{'h1000, 'h1FFF, 'h0C00, 'h0700, 'h2000};

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    chk(tick === 1'b0, "R1 tick", tick, 0);
    chk(ratio_err === 1'b0, "R1 ratio_err", ratio_err, 0);
    chk(active_num == 18'h10000, "R1 active_num", active_num, 'h10000);
    rd(0, v); chk(v == 'h10000, "R1 numerator", v, 'h10000);
    rd(1, v); chk(v == 'h1000, "R1 denominator", v, 'h1000);
    rd(2, v); chk(v == 0, "R1 control", v, 0);

    // R2: numerator low half, fixed upper bits
    cyc(1, 0, 'h2345, 0, 0, "R2");
    rd(0, v); chk(v == 'h12345, "R2 numerator", v, 'h12345);

    // R3: zero denominator rejected, non-zero accepted
    cyc(1, 1, 0, 0, 0, "R3");
    rd(1, v); chk(v == 'h1000, "R3 zero rejected", v, 'h1000);
    cyc(1, 1, 'hC000, 0, 0, "R3");
    rd(1, v); chk(v == 'h1000, "R3 zero low bits rejected", v, 'h1000);
    cyc(1, 1, 'h0ABC, 0, 0, "R3");
    rd(1, v); chk(v == 'h0ABC, "R3 accepted", v, 'h0ABC);

    // R4 / R5: accumulator sweep over several ratios, with mid-run writes
    for (int i = 0; i < 5; i++) begin
      cyc(1, 0, pn[i], 0, 0, "R5");
      cyc(1, 1, pd[i], 0, 0, "R5");
      idle(150, "R4");
      cyc(1, 2, 0, 0, 0, "R5");
      idle(60, "R4");
    end

    // R6: ratio rule at its boundaries per level
    cyc(1, 1, 'h2001, 0, 0, "R6");
    cyc(1, 0, 'h0007, 0, 0, "R6");
    chk(ratio_err === 1'b1, "R6 below 8x", ratio_err, 1);
    idle(40, "R6");
    cyc(1, 0, 'h0008, 0, 0, "R6");
    chk(ratio_err === 1'b0, "R6 equal 8x", ratio_err, 0);
    idle(40, "R6");
    cyc(1, 0, 'h0000, 0, 0, "R6");
    cyc(1, 2, 1, 0, 0, "R6");
    chk(ratio_err === 1'b0, "R6 level 1 4x", ratio_err, 0);
    idle(40, "R6");
    cyc(1, 2, 2, 0, 0, "R6");
    chk(ratio_err === 1'b1, "R6 level 2 8x", ratio_err, 1);
    idle(40, "R6");

    // R7: clamped correction for every limit in correcting levels
    cyc(1, 1, 'h1000, 0, 0, "R7");
    cyc(1, 0, 'h8000, 0, 0, "R7");
    for (int l = 0; l < 3; l++) begin
      for (int lim = 0; lim < 8; lim++) begin
        cyc(1, 2, lv[l] | (lim << 2), 0, 0, "R7");
        for (int k = 0; k < 7; k++) begin
          cyc(0, 0, 0, 1, offs[k], "R7");
          cyc(0, 0, 0, 1, (1 << (lim + 5)) + k - 3, "R7");
        end
      end
    end
    rd(1, v); chk(v == 'h1000, "R7 denominator unchanged", v, 'h1000);

    // R8: level 1 ignores correction
    cyc(1, 2, 1 | (7 << 2), 0, 0, "R8");
    for (int k = 0; k < 7; k++) begin
      cyc(0, 0, 0, 1, offs[k], "R8");
      chk(active_num == 18'h18000, "R8 ignored", active_num, 'h18000);
    end

    // R9: restore on writes, priority over correction
    cyc(1, 2, 0 | (7 << 2), 0, 0, "R9");
    cyc(0, 0, 0, 1, 1000, "R9");
    cyc(1, 0, 'h4000, 1, -1000, "R9");
    chk(active_num == 18'h14000, "R9 numerator write wins", active_num, 'h14000);
    cyc(0, 0, 0, 1, 500, "R9");
    cyc(1, 2, 2 | (3 << 2), 1, 77, "R9");
    chk(active_num == 18'h14000, "R9 control restores", active_num, 'h14000);
    idle(30, "R9");

    // R10: readback layout
    cyc(0, 0, 0, 1, -200, "R10");
    rd(2, v); chk(v == ((3 << 2) | 2), "R10 control", v, (3 << 2) | 2);
    rd(3, v); chk(v == m_nav, "R10 active", v, m_nav);
    rd(0, v); chk(v == 'h14000, "R10 numerator", v, 'h14000);
    rd(1, v); chk(v == m_dc, "R10 denominator", v, m_dc);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule